// File: doc/BRIEF.md
# Pre-Bias Startup Low-Side Gate Stepper

This block sits between the PWM logic of a synchronous buck converter and the low-side switch driver. When the converter starts into an output that is already charged, turning the low-side switch on at full width would discharge the output. The block therefore keeps the low-side drive off until the first high-side pulse has been seen. It then lets the low-side pulse grow in quarter steps of its steady-state width, with a configured number of switching pulses at each step. After the last step it passes the PWM logic's low-side request through unchanged and raises a done flag.

The PWM logic provides the low-side request (`ls_req`) and the steady-state low-side on-time in clock cycles (`ls_ontime`). The high-side gate (`hs_gate_in`) is asynchronous. It goes through two flip-flops, and its falling edge then marks the start of each switching pulse. A start request or a fault reset sends the block back to hold-off. The pulse counts per stage are parameters (defaults 32, 16 and 8).

States: `ST_HOLD` (hold-off, gate low), `ST_Q1` (25 % window), `ST_Q2` (50 %), `ST_Q3` (75 %) and `ST_FULL` (pass-through). Transitions:
- HOLD to Q1 on the first falling edge.
- Q1 to Q2 on the falling edge after 32 pulses in Q1.
- Q2 to Q3 on the falling edge after 16 pulses in Q2.
- Q3 to FULL on the falling edge after 8 pulses in Q3.
- From any state to HOLD on a start request or a fault reset.

Top module: `prebias_ls_stepper`

## Requirements
- R1: After reset, or when in hold-off, `ls_gate_en` stays 0 whatever `ls_req` does, until the first falling edge of `hs_gate_in`.
- R2: In the cycles after the third rising clock edge that follows a falling edge on `hs_gate_in`, a limited stage opens a window of exactly L clock cycles. In that window `ls_gate_en` equals `ls_req`; outside it `ls_gate_en` is 0.
- R3: The falling edge in hold-off starts the first 25 % pulse. Every falling edge counts one pulse. Stage 25 % runs for N25=32 pulses, then 50 % runs for N50=16 pulses, then 75 % runs for N75=8 pulses. The falling edge after those pulses enters pass-through.
- R4: The window length L is floor(T/4) at 25 %, floor(T/2) at 50 % and floor(3T/4) at 75 %, where T is `ls_ontime` sampled at the falling edge. L is never below 1 when T is nonzero.
- R5: In pass-through, `done` is 1 and `ls_gate_en` equals `ls_req`. The state change to pass-through takes effect at the same clock edge at which a window would have opened.
- R6: A one-cycle `start_req` returns the block to hold-off at the next clock edge, clearing `done` and the stage pulse count.
- R7: While `fault_rst` is 1, `ls_gate_en` is 0 in that same cycle. At the next clock edge the block is in hold-off with `done` at 0.
- R8: If `ls_req` falls before the window ends, `ls_gate_en` falls with it.
- R9: A steady-state on-time of 0 gives no low-side pulse in a limited stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, enters hold-off |
| start_req | input | 1 | Start request, restarts from hold-off |
| fault_rst | input | 1 | Fault reset, forces gate low and enters hold-off |
| hs_gate_in | input | 1 | Asynchronous high-side gate strobe |
| ls_req | input | 1 | Low-side on request from the PWM logic |
| ls_ontime | input | OT_W | Steady-state low-side on-time in clock cycles |
| ls_gate_en | output | 1 | Low-side gate enable |
| done | output | 1 | Startup stepping finished, pass-through active |

## Verification
A falling edge on `hs_gate_in`, driven between clock edges, appears as a window from the third rising edge onward. Counting negedge samples k=1,2,... with `ls_req` high for samples 1..m, the bench expects max(0, min(L, m-2)) gated cycles in a limited stage. It expects m in pass-through, and max(0, m-2) on the pulse that enters pass-through. `done` is checked once each pulse has settled. After a start or fault reset it is checked one edge later. The immediate gate-low response to `fault_rst` is sampled within the same cycle, shortly after the input changes.

// File: rtl/prestep_pkg.sv
package prestep_pkg;
    typedef enum logic [2:0] {
        ST_HOLD = 3'd0,
        ST_Q1   = 3'd1,
        ST_Q2   = 3'd2,
        ST_Q3   = 3'd3,
        ST_FULL = 3'd4
    } stage_e;
endpackage

// File: rtl/pb_edge_sync.sv
module pb_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= din;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign fall = s3 & ~s2;
endmodule

// File: rtl/pb_frac_limit.sv
module pb_frac_limit
    import prestep_pkg::*;
#(
    parameter int OT_W = 10
) (
    input  stage_e          stage,
    input  logic [OT_W-1:0] ontime,
    output logic [OT_W-1:0] limit
);
    logic [OT_W+1:0] triple;
    logic [OT_W-1:0] raw;

    always_comb begin
        triple = {2'b00, ontime} + {1'b0, ontime, 1'b0};
        unique case (stage)
            ST_Q1:   raw = ontime >> 2;
            ST_Q2:   raw = ontime >> 1;
            ST_Q3:   raw = triple[OT_W+1:2];
            default: raw = ontime;
        endcase
        if (raw == '0 && ontime != '0)
            limit = OT_W'(1);
        else
            limit = raw;
    end

    // R4: nonzero on-time yields a nonzero limit that never exceeds it
    always_comb begin
        if (ontime != '0) begin
            p_limit_min_r4: assert (limit != '0 && limit <= ontime);
        end
    end
endmodule

// File: rtl/pb_window.sv
module pb_window #(
    parameter int OT_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            load,
    input  logic [OT_W-1:0] limit,
    output logic            active
);
    logic [OT_W-1:0] rem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rem <= '0;
        else if (clr)
            rem <= '0;
        else if (load)
            rem <= limit;
        else if (rem != '0)
            rem <= rem - OT_W'(1);
    end

    assign active = (rem != '0);

    // R2: an open window shrinks by one cycle per clock
    p_win_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rem != '0 && !load && !clr) |=> (rem == $past(rem) - OT_W'(1)));
endmodule

// File: rtl/prebias_ls_stepper.sv
module prebias_ls_stepper
    import prestep_pkg::*;
#(
    parameter int OT_W = 10,
    parameter int N25  = 32,
    parameter int N50  = 16,
    parameter int N75  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_req,
    input  logic            fault_rst,
    input  logic            hs_gate_in,
    input  logic            ls_req,
    input  logic [OT_W-1:0] ls_ontime,
    output logic            ls_gate_en,
    output logic            done
);
    localparam int NMAX = (N25 > N50) ? ((N25 > N75) ? N25 : N75)
                                      : ((N50 > N75) ? N50 : N75);
    localparam int PC_W = $clog2(NMAX + 1);
    localparam logic [PC_W-1:0] C25 = PC_W'(N25);
    localparam logic [PC_W-1:0] C50 = PC_W'(N50);
    localparam logic [PC_W-1:0] C75 = PC_W'(N75);
    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    stage_e          st, st_nx;
    logic [PC_W-1:0] pc, pc_nx;
    logic            hs_fall, clr, load, win_active;
    logic [OT_W-1:0] limit;

    pb_edge_sync u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (hs_gate_in),
        .fall (hs_fall)
    );

    assign clr = start_req | fault_rst;

    always_comb begin
        st_nx = st;
        pc_nx = pc;
        if (clr) begin
            st_nx = ST_HOLD;
            pc_nx = '0;
        end else if (hs_fall) begin
            unique case (st)
                ST_HOLD: begin
                    st_nx = ST_Q1;
                    pc_nx = ONE;
                end
                ST_Q1: begin
                    if (pc == C25) begin st_nx = ST_Q2; pc_nx = ONE; end
                    else pc_nx = pc + ONE;
                end
                ST_Q2: begin
                    if (pc == C50) begin st_nx = ST_Q3; pc_nx = ONE; end
                    else pc_nx = pc + ONE;
                end
                ST_Q3: begin
                    if (pc == C75) begin st_nx = ST_FULL; pc_nx = '0; end
                    else pc_nx = pc + ONE;
                end
                default: begin
                    st_nx = ST_FULL;
                    pc_nx = '0;
                end
            endcase
        end
    end

    assign load = hs_fall && !clr &&
                  (st_nx == ST_Q1 || st_nx == ST_Q2 || st_nx == ST_Q3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_HOLD;
            pc <= '0;
        end else begin
            st <= st_nx;
            pc <= pc_nx;
        end
    end

    pb_frac_limit #(.OT_W(OT_W)) u_limit (
        .stage (st_nx),
        .ontime(ls_ontime),
        .limit (limit)
    );

    pb_window #(.OT_W(OT_W)) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .load  (load),
        .limit (limit),
        .active(win_active)
    );

    always_comb begin
        ls_gate_en = 1'b0;
        done       = 1'b0;
        unique case (st)
            ST_HOLD: ls_gate_en = 1'b0;
            ST_Q1, ST_Q2, ST_Q3: ls_gate_en = win_active & ls_req;
            ST_FULL: begin
                ls_gate_en = ls_req;
                done       = 1'b1;
            end
            default: ls_gate_en = 1'b0;
        endcase
        if (fault_rst)
            ls_gate_en = 1'b0;
    end

    // R1: hold-off keeps the gate off
    p_hold_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> !ls_gate_en);

    // R3: stages advance only in order, or fall back to hold-off
    p_order_q1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_Q1) |=> (st == ST_Q1 || st == ST_Q2 || st == ST_HOLD));
    p_order_q3_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_Q3) |=> (st == ST_Q3 || st == ST_FULL || st == ST_HOLD));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pc <= PC_W'(NMAX));

    // R5: pass-through once done
    p_full_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault_rst) |-> (ls_gate_en == ls_req));

    // R6: start request returns to hold-off
    p_start_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> (!done && !ls_gate_en));

    // R7: fault reset forces the gate low and clears done
    p_fault_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_rst |-> !ls_gate_en);
    p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_rst |=> !done);
endmodule

// File: tb/tb_prebias_ls_stepper.sv
module tb_prebias_ls_stepper;
    localparam int CLK_PERIOD = 10;
    localparam int OT_W = 10;
    localparam int N25 = 32, N50 = 16, N75 = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0, fault_rst = 1'b0, hs = 1'b0, lsr = 1'b0;
    logic [OT_W-1:0] ot = '0;
    logic gate, done;

    int n_cmp = 0, n_bad = 0;
    int stage = 0;   // 0 hold, 1..3 limited, 4 full
    int pcount = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prebias_ls_stepper #(.OT_W(OT_W), .N25(N25), .N50(N50), .N75(N75)) dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .fault_rst(fault_rst),
        .hs_gate_in(hs), .ls_req(lsr), .ls_ontime(ot),
        .ls_gate_en(gate), .done(done)
    );

    function automatic int lim_of(int s, int t);
        int v;
        case (s)
            1: v = t / 4;
            2: v = t / 2;
            3: v = (3 * t) / 4;
            default: v = t;
        endcase
        if (v == 0 && t > 0) v = 1;
        return v;
    endfunction

    function automatic int stage_len(int s);
        return (s == 1) ? N25 : (s == 2) ? N50 : N75;
    endfunction

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one switching pulse: hs high for hi cycles, then ls_req high for m samples
    task automatic do_pulse(int hi, int m, string req);
        int prev, L, exp, cnt, kmax;
        @(negedge clk); hs = 1'b1;
        repeat (hi) @(negedge clk);
        prev = stage;
        if (stage == 0) begin stage = 1; pcount = 1; end
        else if (stage < 4) begin
            if (pcount == stage_len(stage)) begin
                stage++; pcount = (stage == 4) ? 0 : 1;
            end else pcount++;
        end
        L = lim_of(stage, int'(ot));
        if (stage < 4) exp = (m - 2 < L) ? ((m - 2 > 0) ? m - 2 : 0) : L;
        else if (prev < 4) exp = (m - 2 > 0) ? m - 2 : 0;
        else exp = m;
        hs = 1'b0; lsr = 1'b1;
        cnt = 0;
        kmax = ((m > L + 3) ? m : L + 3) + 1;
        for (int k = 1; k <= kmax; k++) begin
            @(negedge clk);
            if (gate) cnt++;
            if (k == m) lsr = 1'b0;
        end
        check(req, cnt, exp);
        check("R5", int'(done), int'(stage == 4));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        int m;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset gate", int'(gate), 0);
        check("R1 reset done", int'(done), 0);
        lsr = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R1 hold ignores ls_req", int'(gate), 0);
        end
        lsr = 1'b0;

        // Run 1: full stepping, wide requests so each window shows its length
        for (int p = 0; p < N25 + N50 + N75 + 3; p++) begin
            ot = OT_W'(8 + ($urandom % 37));
            do_pulse(3 + ($urandom % 6), 50, (stage < 3) ? "R3" : "R4");
        end

        // R6: start request from pass-through
        @(negedge clk); start_req = 1'b1; lsr = 1'b1;
        @(negedge clk); start_req = 1'b0;
        stage = 0; pcount = 0;
        check("R6 done cleared", int'(done), 0);
        check("R6 gate held off", int'(gate), 0);
        lsr = 1'b0;

        // Run 2: corner on-times and short requests
        ot = '0;        do_pulse(4, 20, "R9");
        ot = OT_W'(1);  do_pulse(4, 20, "R4");
        ot = OT_W'(3);  do_pulse(4, 20, "R4");
        ot = OT_W'(40); do_pulse(4, 5, "R8");
        ot = OT_W'(40); do_pulse(4, 2, "R8");
        for (int p = 0; p < N25 + 5; p++) begin
            ot = OT_W'(1 + ($urandom % 60));
            m = 1 + ($urandom % (lim_of(2, int'(ot)) + 5));
            do_pulse(3 + ($urandom % 6), m, "R2");
        end
        // now in the 50% stage: restart
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
        stage = 0; pcount = 0;
        ot = OT_W'(40); do_pulse(4, 50, "R6");
        for (int p = 0; p < N25 + N50 + N75 + 1; p++) begin
            ot = OT_W'(1 + ($urandom % 60));
            m = 1 + ($urandom % (int'(ot) + 4));
            do_pulse(3 + ($urandom % 6), m, "R3");
        end
        ot = OT_W'(20); do_pulse(4, 6, "R5");

        // R7: fault while passing through
        @(negedge clk); lsr = 1'b1;
        #1;
        check("R5 pass-through", int'(gate), 1);
        fault_rst = 1'b1;
        #1;
        check("R7 gate forced low", int'(gate), 0);
        @(negedge clk);
        check("R7 done cleared", int'(done), 0);
        fault_rst = 1'b0; lsr = 1'b0;
        stage = 0; pcount = 0;
        @(negedge clk);
        check("R7 hold after fault", int'(gate), 0);
        ot = OT_W'(40); do_pulse(4, 50, "R7");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule